// File: doc/BRIEF.md
# Burst SPI Master with Register Window

This block is a serial-peripheral-interface master that software drives through a window of eight 32-bit register slots. Software first writes the link settings into the control slot with the enable bit set. These settings are clock polarity, clock phase, select polarity, word length, rate and target select. Software then queues up to four words into the transmit slot. Setting the exchange bit starts a burst.

During a burst the block shifts each queued word out most-significant-bit first, over the programmed number of bits. At the same time it collects the bits arriving on the input line into a receive queue, one word for each word sent. When the transmit queue has drained, the block raises a completion flag and clears the exchange bit. Software reads the received words back from the receive slot, one read per word.

Two status flags, completion and receive overflow, are cleared by writing one to them. An enable register selects which flags reach the level interrupt output. Clearing the enable bit aborts any activity and empties both queues.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the control, status and receive slots read zero, `sclk` and `mosi` are low, `cs_out` is all ones (deasserted at select polarity 0) and `irq` is low.
- R2: Writes to the transmit slot (word offset 0x04) are queued, up to four words, and further writes while the queue is full are dropped. No clock edge appears and no select asserts until the exchange bit (control bit 2) is written as one together with enable (control bit 0).
- R3: Each word is sent over len+1 clock periods, where len is control bits 12:8. The bits sent are word bits len down to 0, most significant first, and the words go out in queue order.
- R4: Each received word lands right-aligned in the receive slot (offset 0x00) with zeros above bit len. Words come back in arrival order, each read takes one word off the queue, and reading an empty queue returns zero.
- R5: One `sclk` period lasts 4·2^rate system clocks, where rate is control bits 18:16, and the clock runs without gaps across word boundaries. Outside a burst `sclk` rests at the polarity bit (control bit 4).
- R6: With the phase bit (control bit 5) at 0, the first clock edge comes half a period after select assertion, and `mosi` is sampled on leading edges. With the phase bit at 1, the first edge coincides with select assertion, and `mosi` is sampled on trailing edges.
- R7: During a burst exactly one select line, the one numbered by control bits 25:24, sits at the select-polarity level (control bit 7). It stays there from the first word to the last, and all other lines hold the opposite level.
- R8: Completion (status bit 8, offset 0x14) sets when the last queued word has finished. The exchange bit reads back zero from then on, and writing one to status bit 8 clears the flag.
- R9: A word that completes while the receive queue holds four words is dropped and sets overflow (status bit 6). Writing one to that bit clears it.
- R10: Writing enable low stops the burst at the next clock, returns `sclk` to idle, deasserts all selects and empties both queues. A completion flag is not raised by the abort.
- R11: `irq` is high exactly while completion is set with interrupt-enable bit 8 (offset 0x0C), or overflow is set with interrupt-enable bit 6.
- R12: Writing the exchange bit while the transmit queue is empty sets completion within two cycles and generates no clock edges.
- R13: Offsets 0x10, 0x18 and 0x1C read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x00) |
| reg_addr | input | 5 | Byte offset of the register slot |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Select lines, active level set by the select-polarity bit |
| irq | output | 1 | Level interrupt flag |

## Verification
The bench aims at word lengths of 1 and 32 bits and at bursts of one to four words in every polarity and phase mix. A design with an off-by-one in the length field would send the wrong number of bits, or drop the top bit. A phase mix-up shows up as the first clock edge landing at the wrong distance from select assertion. The bench queues five words to show that the fifth is dropped, and runs two bursts without reading in between to show that the second burst is discarded and flagged rather than overwriting stored words. It also aborts a slow burst by clearing enable, then issues an exchange with nothing queued. A design that kept stale transmit words would start shifting instead of completing at once.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = $clog2(WORD_W);
  localparam int unsigned RATE_W   = 3;
  localparam int unsigned NUM_SEL  = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_SEL);

  // word index of each slot (byte offset / 4)
  localparam int unsigned SLOT_RX   = 0;
  localparam int unsigned SLOT_TX   = 1;
  localparam int unsigned SLOT_CTRL = 2;
  localparam int unsigned SLOT_IEN  = 3;
  localparam int unsigned SLOT_STAT = 5;

  // control slot bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_MST   = 1;
  localparam int unsigned CB_XCH   = 2;
  localparam int unsigned CB_POL   = 4;
  localparam int unsigned CB_PHA   = 5;
  localparam int unsigned CB_SSCTL = 6;
  localparam int unsigned CB_SSPOL = 7;
  localparam int unsigned CB_LEN   = 8;
  localparam int unsigned CB_RATE  = 16;
  localparam int unsigned CB_SEL   = 24;

  // status / interrupt-enable bit positions
  localparam int unsigned SB_DONE  = 8;
  localparam int unsigned SB_OVF   = 6;

  typedef struct packed {
    logic              pol;
    logic              pha;
    logic              sspol;
    logic [LEN_W-1:0]  len_m1;
    logic [RATE_W-1:0] rate;
    logic [SEL_W-1:0]  sel;
  } link_cfg_t;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign rdata   = mem_q[rp_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wp_q == AW'(g)) mem_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int unsigned RATE_BITS = 3,
  localparam int unsigned MAX_HALF = 2 << ((1 << RATE_BITS) - 1),
  localparam int unsigned CW       = $clog2(MAX_HALF) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [RATE_BITS-1:0] rate,
  output logic                 tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  // half period = 2 << rate system clocks
  assign last = (CW'(2) << rate) - CW'(1);
  assign tick = run && (cnt_q == last);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  link_cfg_t         cfg,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              busy,
  output logic              sclk,
  output logic              mosi
);

  eng_state_t        st_q, st_d;
  logic              half_q, half_d;
  logic [LEN_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] tx_sh_q;
  logic [WORD_W-1:0] rx_sh_q, rx_sh_d;
  logic              tick;

  spi_rate_div #(.RATE_BITS(RATE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ENG_SHIFT),
    .rate (cfg.rate),
    .tick (tick)
  );

  always_comb begin
    st_d    = st_q;
    half_d  = half_q;
    bit_d   = bit_q;
    rx_sh_d = rx_sh_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    done    = 1'b0;
    if (!en) begin
      st_d   = ENG_IDLE;
      half_d = 1'b0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (start) begin
            if (tx_empty) begin
              done = 1'b1;
            end else begin
              tx_pop  = 1'b1;
              rx_sh_d = '0;
              bit_d   = cfg.len_m1;
              half_d  = 1'b0;
              st_d    = ENG_SHIFT;
            end
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            if (!half_q) begin
              half_d  = 1'b1;
              rx_sh_d = {rx_sh_q[WORD_W-2:0], miso};
            end else begin
              half_d = 1'b0;
              if (bit_q == '0) begin
                rx_push = 1'b1;
                if (!tx_empty) begin
                  tx_pop  = 1'b1;
                  rx_sh_d = '0;
                  bit_d   = cfg.len_m1;
                end else begin
                  st_d = ENG_IDLE;
                  done = 1'b1;
                end
              end else begin
                bit_d = bit_q - 1'b1;
              end
            end
          end
        end
        default: st_d = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      half_q  <= 1'b0;
      bit_q   <= '0;
      rx_sh_q <= '0;
    end else begin
      st_q    <= st_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
      rx_sh_q <= rx_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_sh_q <= '0;
    else if (tx_pop) tx_sh_q <= tx_word;
  end

  assign busy    = (st_q == ENG_SHIFT);
  assign rx_word = rx_sh_q;
  assign mosi    = busy ? tx_sh_q[bit_q] : 1'b0;
  // phase 0: active level in second half; phase 1: active in first half
  assign sclk    = cfg.pol ^ (busy & (cfg.pha ? ~half_q : half_q));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned ADDR_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] cs_out,
  output logic               irq
);

  localparam int unsigned SLOT_W = ADDR_W - 2;
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH) + 1;

  logic [SLOT_W-1:0] slot;
  logic wr_tx, wr_ctrl, wr_ien, wr_stat, rd_rx;

  logic      en_q, en_d, mst_q, mst_d, ssctl_q, ssctl_d, xch_q, xch_d;
  link_cfg_t cfg_q, cfg_d;
  logic      ie_done_q, ie_done_d, ie_ovf_q, ie_ovf_d;
  logic      done_q, done_d, ovf_q, ovf_d;

  logic              tx_empty, tx_full, tx_pop;
  logic [WORD_W-1:0] tx_head;
  logic [CNT_W-1:0]  tx_count;
  logic              rx_empty, rx_full, rx_push;
  logic [WORD_W-1:0] rx_head, rx_word;
  logic [CNT_W-1:0]  rx_count;
  logic              eng_done, eng_busy;
  logic [WORD_W-1:0] ctrl_view;

  assign slot    = reg_addr[ADDR_W-1:2];
  assign wr_tx   = reg_wr && (slot == SLOT_W'(SLOT_TX));
  assign wr_ctrl = reg_wr && (slot == SLOT_W'(SLOT_CTRL));
  assign wr_ien  = reg_wr && (slot == SLOT_W'(SLOT_IEN));
  assign wr_stat = reg_wr && (slot == SLOT_W'(SLOT_STAT));
  assign rd_rx   = reg_rd && (slot == SLOT_W'(SLOT_RX)) && !rx_empty;

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(!en_q),
    .push (wr_tx),
    .wdata(reg_wdata),
    .pop  (tx_pop),
    .rdata(tx_head),
    .empty(tx_empty),
    .full (tx_full),
    .count(tx_count)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(!en_q),
    .push (rx_push),
    .wdata(rx_word),
    .pop  (rd_rx),
    .rdata(rx_head),
    .empty(rx_empty),
    .full (rx_full),
    .count(rx_count)
  );

  spi_shift_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .start   (xch_q),
    .cfg     (cfg_q),
    .tx_empty(tx_empty),
    .tx_word (tx_head),
    .miso    (miso),
    .tx_pop  (tx_pop),
    .rx_push (rx_push),
    .rx_word (rx_word),
    .done    (eng_done),
    .busy    (eng_busy),
    .sclk    (sclk),
    .mosi    (mosi)
  );

  // register next state
  always_comb begin
    en_d      = en_q;
    mst_d     = mst_q;
    ssctl_d   = ssctl_q;
    cfg_d     = cfg_q;
    xch_d     = xch_q;
    ie_done_d = ie_done_q;
    ie_ovf_d  = ie_ovf_q;
    done_d    = done_q;
    ovf_d     = ovf_q;
    if (wr_ctrl) begin
      en_d         = reg_wdata[CB_EN];
      mst_d        = reg_wdata[CB_MST];
      ssctl_d      = reg_wdata[CB_SSCTL];
      cfg_d.pol    = reg_wdata[CB_POL];
      cfg_d.pha    = reg_wdata[CB_PHA];
      cfg_d.sspol  = reg_wdata[CB_SSPOL];
      cfg_d.len_m1 = reg_wdata[CB_LEN +: LEN_W];
      cfg_d.rate   = reg_wdata[CB_RATE +: RATE_W];
      cfg_d.sel    = reg_wdata[CB_SEL +: SEL_W];
      xch_d        = reg_wdata[CB_XCH] & reg_wdata[CB_EN];
    end else if (eng_done || !en_q) begin
      xch_d = 1'b0;
    end
    if (wr_ien) begin
      ie_done_d = reg_wdata[SB_DONE];
      ie_ovf_d  = reg_wdata[SB_OVF];
    end
    if (eng_done)                            done_d = 1'b1;
    else if (wr_stat && reg_wdata[SB_DONE])  done_d = 1'b0;
    if (rx_push && rx_full)                  ovf_d = 1'b1;
    else if (wr_stat && reg_wdata[SB_OVF])   ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mst_q     <= 1'b0;
      ssctl_q   <= 1'b0;
      cfg_q     <= '0;
      xch_q     <= 1'b0;
      ie_done_q <= 1'b0;
      ie_ovf_q  <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      en_q      <= en_d;
      mst_q     <= mst_d;
      ssctl_q   <= ssctl_d;
      cfg_q     <= cfg_d;
      xch_q     <= xch_d;
      ie_done_q <= ie_done_d;
      ie_ovf_q  <= ie_ovf_d;
      done_q    <= done_d;
      ovf_q     <= ovf_d;
    end
  end

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[CB_EN]                 = en_q;
    ctrl_view[CB_MST]                = mst_q;
    ctrl_view[CB_XCH]                = xch_q;
    ctrl_view[CB_POL]                = cfg_q.pol;
    ctrl_view[CB_PHA]                = cfg_q.pha;
    ctrl_view[CB_SSCTL]              = ssctl_q;
    ctrl_view[CB_SSPOL]              = cfg_q.sspol;
    ctrl_view[CB_LEN +: LEN_W]       = cfg_q.len_m1;
    ctrl_view[CB_RATE +: RATE_W]     = cfg_q.rate;
    ctrl_view[CB_SEL +: SEL_W]       = cfg_q.sel;
  end

  always_comb begin
    reg_rdata = '0;
    case (slot)
      SLOT_W'(SLOT_RX):   reg_rdata = rx_empty ? '0 : rx_head;
      SLOT_W'(SLOT_CTRL): reg_rdata = ctrl_view;
      SLOT_W'(SLOT_IEN): begin
        reg_rdata[SB_DONE] = ie_done_q;
        reg_rdata[SB_OVF]  = ie_ovf_q;
      end
      SLOT_W'(SLOT_STAT): begin
        reg_rdata[SB_DONE] = done_q;
        reg_rdata[SB_OVF]  = ovf_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign cs_out[g] = (eng_busy && cfg_q.sel == SEL_W'(g)) ? cfg_q.sspol : ~cfg_q.sspol;
  end

  assign irq = (done_q & ie_done_q) | (ovf_q & ie_ovf_q);

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk
  import spi_burst_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk,
  input logic [NUM_SEL-1:0] cs_out,
  input logic               busy,
  input logic               en,
  input logic               pol,
  input logic               sspol,
  input logic               xch,
  input logic               done,
  input logic               ovf,
  input logic [CNT_W-1:0]   rx_count
);

  p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(cs_out ^ {NUM_SEL{~sspol}}) == 1);

  p_no_select_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $countones(cs_out ^ {NUM_SEL{~sspol}}) == 0);

  p_idle_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == pol);

  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  p_done_clears_xch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !xch);

  p_ovf_only_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rx_count) == CNT_W'(DEPTH));

  p_rx_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sclk    (sclk),
  .cs_out  (cs_out),
  .busy    (eng_busy),
  .en      (en_q),
  .pol     (cfg_q.pol),
  .sspol   (cfg_q.sspol),
  .xch     (xch_q),
  .done    (done_q),
  .ovf     (ovf_q),
  .rx_count(rx_count)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;

  localparam logic [4:0] A_RX = 5'h00, A_TX = 5'h04, A_CTRL = 5'h08, A_IEN = 5'h0C;
  localparam logic [4:0] A_DMA = 5'h10, A_STAT = 5'h14, A_PER = 5'h18, A_TST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso, irq;
  logic [3:0]  cs_out;

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_burst_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bus-side view of current settings
  bit   cfg_pol, cfg_pha, cfg_sspol;
  int   cfg_sel, cfg_bits, cfg_rate;

  // serial monitor
  bit          mon_on = 0;
  logic [31:0] mon_sh;
  int          mon_n, mon_wcnt, mon_cs_err, mon_per_err;
  logic [31:0] mon_words [8];
  realtime     mon_t, cs_t, first_clk_t;
  bit          mon_have_t, cs_seen, clk_seen;

  function automatic logic [31:0] mask_of(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [3:0] sel_vec(int sel, bit sspol, bit active);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (active && i == sel) ? sspol : ~sspol;
    return v;
  endfunction

  function automatic logic [31:0] make_ctrl(bit en, bit xch, bit pol, bit pha, bit sspol,
                                            int bits, int rate, int sel);
    logic [31:0] c;
    c = '0;
    c[0] = en; c[1] = 1'b1; c[2] = xch; c[4] = pol; c[5] = pha; c[7] = sspol;
    c[12:8]  = 5'(bits - 1);
    c[18:16] = 3'(rate);
    c[25:24] = 2'(sel);
    return c;
  endfunction

  always @(sclk) begin
    if (mon_on) begin
      bit leading;
      if (!clk_seen) begin
        clk_seen    = 1;
        first_clk_t = $realtime;
      end
      leading = (sclk != cfg_pol);
      if (leading != cfg_pha) begin
        mon_sh = {mon_sh[30:0], mosi};
        mon_n++;
        if (cs_out !== sel_vec(cfg_sel, cfg_sspol, 1'b1)) mon_cs_err++;
        if (mon_have_t && ($realtime - mon_t) != real'((4 << cfg_rate) * 4)) mon_per_err++;
        mon_t = $realtime;
        mon_have_t = 1;
        if (mon_n == cfg_bits) begin
          if (mon_wcnt < 8) mon_words[mon_wcnt] = mon_sh & mask_of(cfg_bits);
          mon_wcnt++;
          mon_n  = 0;
          mon_sh = '0;
        end
      end
    end
  end

  always @(cs_out) begin
    if (mon_on && !cs_seen && cs_out === sel_vec(cfg_sel, cfg_sspol, 1'b1)) begin
      cs_seen = 1;
      cs_t    = $realtime;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic mon_clear();
    mon_sh = '0; mon_n = 0; mon_wcnt = 0; mon_cs_err = 0; mon_per_err = 0;
    mon_have_t = 0; cs_seen = 0; clk_seen = 0;
  endtask

  task automatic wait_done(int limit, output bit got);
    logic [31:0] d;
    got = 0;
    for (int k = 0; k < limit; k++) begin
      rd(A_STAT, d);
      if (d[8]) begin got = 1; break; end
    end
  endtask

  task automatic run_burst(int sel, int rate, bit pol, bit pha, bit sspol, int bits,
                           int nw, logic [31:0] w [4], bit extra, bit read_back);
    logic [31:0] ctrl, d;
    bit got;
    ctrl = make_ctrl(1'b1, 1'b0, pol, pha, sspol, bits, rate, sel);
    wr(A_CTRL, ctrl);
    cfg_pol = pol; cfg_pha = pha; cfg_sspol = sspol;
    cfg_sel = sel; cfg_bits = bits; cfg_rate = rate;
    for (int i = 0; i < nw; i++) wr(A_TX, w[i]);
    if (extra) wr(A_TX, 32'hA5A5_5A5A);
    mon_clear();
    mon_on = 1;
    repeat (20) @(negedge clk);
    // R2: nothing moves before the exchange bit
    chk("R2 no clocks before exchange", 32'(mon_n + mon_wcnt), 32'd0);
    chk("R2 select idle before exchange", 32'(cs_out), 32'(sel_vec(sel, sspol, 1'b0)));
    wr(A_CTRL, ctrl | 32'h4);
    wait_done(40000, got);
    mon_on = 0;
    chk("R8 completion set", 32'(got), 32'd1);
    rd(A_CTRL, d);
    chk("R8 exchange self-clears", 32'(d[2]), 32'd0);
    chk("R7 select released after burst", 32'(cs_out), 32'(sel_vec(sel, sspol, 1'b0)));
    chk("R5 clock idles at polarity", 32'(sclk), 32'(pol));
    chk("R3 word count sent", 32'(mon_wcnt), 32'(nw));
    for (int i = 0; i < nw && i < 4; i++)
      chk("R3 serial word", mon_words[i], w[i] & mask_of(bits));
    chk("R7 select held during bits", 32'(mon_cs_err), 32'd0);
    chk("R5 clock period", 32'(mon_per_err), 32'd0);
    chk("R6 first edge offset", 32'(int'((first_clk_t - cs_t) / 4.0)),
        pha ? 32'd0 : 32'(2 << rate));
    if (read_back) begin
      for (int i = 0; i < nw; i++) begin
        rd(A_RX, d);
        chk("R4 received word", d, ~w[i] & mask_of(bits));
      end
      rd(A_RX, d);
      chk("R4 empty queue reads zero", d, 32'd0);
    end
    wr(A_STAT, 32'h100);
    rd(A_STAT, d);
    chk("R8 completion write-one-clear", 32'(d[8]), 32'd0);
  endtask

  task automatic finish_test();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_test();
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [31:0] w [4];
    logic [31:0] wb [4];
    bit got;
    int seed;
    seed = $urandom(32'd4242);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk low", 32'(sclk), 32'd0);
    chk("R1 mosi low", 32'(mosi), 32'd0);
    chk("R1 selects deasserted", 32'(cs_out), 32'hF);
    chk("R1 irq low", 32'(irq), 32'd0);
    rd(A_CTRL, d); chk("R1 control zero", d, 32'd0);
    rd(A_STAT, d); chk("R1 status zero", d, 32'd0);
    rd(A_RX, d);   chk("R1 receive zero", d, 32'd0);

    // directed: length corners
    w = '{32'h8000_0001, 32'h1234_5678, 32'hFFFF_0000, 32'h0F0F_F0F0};
    run_burst(0, 0, 1'b0, 1'b0, 1'b0, 32, 4, w, 1'b0, 1'b1);
    run_burst(3, 1, 1'b1, 1'b1, 1'b1, 1, 3, w, 1'b0, 1'b1);
    // R2: fifth queued word dropped
    run_burst(2, 0, 1'b0, 1'b1, 1'b0, 8, 4, w, 1'b1, 1'b1);

    // random bursts
    for (int t = 0; t < 8; t++) begin
      logic [31:0] wr_rand [4];
      for (int i = 0; i < 4; i++) wr_rand[i] = $urandom;
      run_burst($urandom_range(0, 3), $urandom_range(0, 2), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(1, 32),
                $urandom_range(1, 4), wr_rand, 1'b0, 1'b1);
    end

    // R9 overflow: two full bursts without reading
    w  = '{32'h11, 32'h22, 32'h33, 32'h44};
    wb = '{32'h55, 32'h66, 32'h77, 32'h88};
    run_burst(1, 0, 1'b0, 1'b0, 1'b0, 8, 4, w, 1'b0, 1'b0);
    rd(A_STAT, d);
    chk("R9 no overflow while room", 32'(d[6]), 32'd0);
    run_burst(1, 0, 1'b0, 1'b0, 1'b0, 8, 4, wb, 1'b0, 1'b0);
    rd(A_STAT, d);
    chk("R9 overflow flagged", 32'(d[6]), 32'd1);
    wr(A_IEN, 32'h40);
    @(negedge clk);
    chk("R11 irq from overflow", 32'(irq), 32'd1);
    for (int i = 0; i < 4; i++) begin
      rd(A_RX, d);
      chk("R9 stored words kept", d, ~w[i] & 32'hFF);
    end
    rd(A_RX, d);
    chk("R9 dropped words absent", d, 32'd0);
    wr(A_STAT, 32'h40);
    rd(A_STAT, d);
    chk("R9 overflow write-one-clear", 32'(d[6]), 32'd0);
    chk("R11 irq drops with flag", 32'(irq), 32'd0);
    wr(A_IEN, 32'h0);

    // R10 abort mid-burst, then R12 empty exchange
    cfg_pol = 1'b1; cfg_sspol = 1'b1;
    wr(A_CTRL, make_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32, 7, 2));
    wr(A_TX, 32'hDEAD_BEEF);
    wr(A_TX, 32'hCAFE_F00D);
    wr(A_CTRL, make_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32, 7, 2));
    repeat (2000) @(negedge clk);
    chk("R7 select active mid-burst", 32'(cs_out), 32'h4);
    wr(A_CTRL, make_ctrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32, 7, 2));
    @(negedge clk);
    chk("R10 selects released on abort", 32'(cs_out), 32'h0);
    chk("R10 clock idle on abort", 32'(sclk), 32'd1);
    rd(A_STAT, d);
    chk("R10 no completion from abort", 32'(d[8]), 32'd0);
    wr(A_CTRL, make_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32, 7, 2));
    rd(A_RX, d);
    chk("R10 receive queue emptied", d, 32'd0);
    mon_clear();
    cfg_pha = 1'b0; cfg_sel = 2; cfg_bits = 32; cfg_rate = 7;
    mon_on = 1;
    wr(A_CTRL, make_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32, 7, 2));
    wait_done(2, got);
    mon_on = 0;
    chk("R12 empty exchange completes at once", 32'(got), 32'd1);
    chk("R10 transmit queue emptied", 32'(clk_seen), 32'd0);

    // R11 interrupt gating on completion
    chk("R11 irq masked", 32'(irq), 32'd0);
    wr(A_IEN, 32'h100);
    @(negedge clk);
    chk("R11 irq from completion", 32'(irq), 32'd1);
    wr(A_STAT, 32'h100);
    @(negedge clk);
    chk("R11 irq clears with flag", 32'(irq), 32'd0);
    wr(A_IEN, 32'h0);

    // R13 unused slots
    rd(A_CTRL, d);
    wr(A_DMA, 32'hFFFF_FFFF);
    wr(A_PER, 32'hFFFF_FFFF);
    wr(A_TST, 32'hFFFF_FFFF);
    rd(A_PER, d2); chk("R13 unused slot reads zero", d2, 32'd0);
    rd(A_DMA, d2); chk("R13 unused slot reads zero", d2, 32'd0);
    rd(A_TST, d2); chk("R13 unused slot reads zero", d2, 32'd0);
    rd(A_CTRL, d2); chk("R13 control untouched", d2, d);
    rd(A_STAT, d2); chk("R13 status untouched", d2, 32'd0);

    finish_test();
  end

endmodule